// File: doc/BRIEF.md
# Nibble-Field Priority Interrupt Controller

This block arbitrates 28 interrupt sources for a CPU. Four 32-bit control registers each hold eight 4-bit per-source fields. A field holds a 3-bit priority level, and its top bit qualifies a write. A single register write can therefore reprogram or acknowledge one source and leave the other seven in that register as they were. A source at priority zero is masked.

Six sources are external lines: source indices 0 to 3 and 25 to 26. The block catches a rising edge on each of these into a sticky pending flag. Software clears that flag with a qualified write to the source's field. The other 22 sources are internal and level-sensitive, so their pending state is simply their input.

On every cycle the block picks the pending, unmasked source with the highest level. A tie goes to the lower index. The block then presents the winning level and a vector number to the CPU through registered outputs. The vector is 65 plus the source index. Vector 64 means that nothing is pending.

Top module: `nibble_irq_ctrl`

## Requirements
- R1: After reset every priority field and every pending flag is zero, every register reads 0x00000000, irq_level is 0 and irq_vector is 64.
- R2: Source i lives in register i/8 at bits [31-4*(i%8) : 28-4*(i%8)], and reading that field returns {pending, priority[2:0]}. The four fields of register 3 that have no source (bits 15:0) always read zero, and writes to them have no effect.
- R3: A nibble written with bit 3 set loads bits 2:0 into that source's priority. A nibble written with bit 3 clear leaves that source's priority and pending state unchanged.
- R4: A source whose priority is 0 never wins arbitration. Field value 0x8 masks a source, and field value 0xD enables it at level 5.
- R5: An external source sets its pending flag on a rising edge of its input. The flag stays set after the input falls.
- R6: A qualified write (bit 3 set) to an external source's field clears its pending flag. If a rising edge arrives in the same cycle, the edge wins.
- R7: An internal source is pending exactly while its input is high and needs no acknowledge.
- R8: The pending, unmasked source with the highest level wins, and a tie goes to the lower index. The outputs are irq_level equal to the winner's level and irq_vector equal to 65 plus its index. The outputs are registered: an internal input appears one clock later, while an external edge or a priority write appears two clocks later.
- R9: When no pending source is unmasked, irq_level is 0 and irq_vector is 64.
- R10: Writing 0x88888888 to all four registers leaves no source able to win, so irq_level returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register selected for the write |
| wr_data | input | 32 | Write data, eight 4-bit fields |
| rd_sel | input | 2 | Register selected for the read |
| rd_data | output | 32 | Combinational read data of the selected register |
| src_in | input | 28 | Interrupt request inputs, index 0 maps to vector 65 |
| irq_level | output | 3 | Level of the winning source, 0 when none |
| irq_vector | output | 8 | Vector of the winning source, 64 when none |

## Verification
A wrong priority or pending state shows up within two clocks as a wrong irq_level or irq_vector. It can also show up at once in rd_data, because the read returns the pending flag and the level together. If the sticky logic is wrong, the output falls back to level 0 or to a lower source as soon as an external input drops. If a write qualifier is wrong, a source that should not have been touched moves. The bench drives each of these situations and compares the outputs against expected results that it works out from the field layout.

// File: rtl/nibble_irq_ctrl.sv
module nibble_irq_ctrl #(
  parameter int NSRC = 28,
  parameter logic [NSRC-1:0] EXT_MASK = 28'h600000F,
  parameter int VEC_BASE = 64
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [$clog2((NSRC+7)/8)-1:0]       wr_sel,
  input  logic [31:0]                         wr_data,
  input  logic [$clog2((NSRC+7)/8)-1:0]       rd_sel,
  output logic [31:0]                         rd_data,
  input  logic [NSRC-1:0]                     src_in,
  output logic [2:0]                          irq_level,
  output logic [7:0]                          irq_vector
);
  localparam int NREG = (NSRC + 7) / 8;
  localparam int SELW = $clog2(NREG);

  logic [NSRC-1:0][2:0] prio;
  logic [NSRC-1:0]      pend_q;
  logic [NSRC-1:0]      src_q;
  logic [NSRC-1:0]      pending;
  logic [NSRC-1:0]      hit;
  logic [2:0]           best_lvl;
  logic [7:0]           best_idx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) src_q <= '0;
    else        src_q <= src_in;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam int TOP = 31 - 4 * (i % 8);
    assign hit[i] = wr_en && (wr_sel == SELW'(i / 8)) && wr_data[TOP];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      prio[i] <= '0;
      else if (hit[i]) prio[i] <= wr_data[TOP-1 -: 3];

    if (EXT_MASK[i]) begin : g_ext
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pend_q[i] <= 1'b0;
        else        pend_q[i] <= (src_in[i] & ~src_q[i]) | (pend_q[i] & ~hit[i]);
      assign pending[i] = pend_q[i];

      p_edge_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_in[i] && !src_q[i]) |=> pending[i]);
      p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pending[i] && !hit[i]) |=> pending[i]);
      p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[i] && !(src_in[i] && !src_q[i])) |=> !pending[i]);
    end else begin : g_int
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pend_q[i] <= 1'b0;
        else        pend_q[i] <= 1'b0;
      assign pending[i] = src_in[i];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NSRC; i++)
      if (rd_sel == SELW'(i / 8))
        rd_data[31 - 4 * (i % 8) -: 4] = {pending[i], prio[i]};
  end

  always_comb begin
    best_lvl = '0;
    best_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pending[i] && prio[i] != 3'd0 && prio[i] >= best_lvl) begin
        best_lvl = prio[i];
        best_idx = 8'(i);
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq_level  <= '0;
      irq_vector <= 8'(VEC_BASE);
    end else begin
      irq_level  <= best_lvl;
      irq_vector <= (best_lvl == 3'd0) ? 8'(VEC_BASE) : 8'(VEC_BASE + 1) + best_idx;
    end

  p_idle_vector_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level == 3'd0) |-> (irq_vector == 8'(VEC_BASE)));
  p_vector_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != 3'd0) |-> (irq_vector > 8'(VEC_BASE) && irq_vector <= 8'(VEC_BASE + NSRC)));
  p_no_write_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(prio));
  p_masked_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (prio == '0) |=> (irq_level == 3'd0));
endmodule

// File: tb/nibble_irq_ctrl_bench.sv
module nibble_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic [27:0] src_in = '0;
  logic [2:0]  irq_level;
  logic [7:0]  irq_vector;

  int checks = 0;
  int failures = 0;
  typedef struct { logic [2:0] lvl; logic [7:0] vec; string tag; } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  nibble_irq_ctrl u_nibble_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .src_in(src_in),
    .irq_level(irq_level), .irq_vector(irq_vector));

  task automatic write_reg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic set_src(input int idx, input logic v);
    @(negedge clk);
    src_in[idx] = v;
  endtask

  task automatic expect_out(input logic [2:0] lvl, input logic [7:0] vec, input string tag);
    exp_t e;
    repeat (3) @(negedge clk);
    e.lvl = lvl; e.vec = vec; e.tag = tag;
    q.push_back(e);
    wait (q.size() == 0);
  endtask

  task automatic check_rd(input logic [1:0] sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_sel = sel;
    #1;
    checks++;
    if (rd_data !== exp) begin
      failures++;
      $display("FAIL %s: reg%0d read actual=%h expected=%h", tag, sel, rd_data, exp);
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (irq_level !== e.lvl || irq_vector !== e.vec) begin
          failures++;
          $display("FAIL %s: actual level=%0d vector=%0d expected level=%0d vector=%0d",
                   e.tag, irq_level, irq_vector, e.lvl, e.vec);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_out(3'd0, 8'd64, "R1 reset outputs");
    for (int r = 0; r < 4; r++) check_rd(2'(r), 32'h0, "R1 reset registers");

    write_reg(2'd0, 32'hD000_0000);
    check_rd(2'd0, 32'h5000_0000, "R2 R3 field 0 layout");
    expect_out(3'd0, 8'd64, "R9 enabled but idle");

    set_src(0, 1'b1);
    expect_out(3'd5, 8'd65, "R5 R4 external edge at level 5");
    set_src(0, 1'b0);
    expect_out(3'd5, 8'd65, "R5 sticky after input falls");
    check_rd(2'd0, 32'hD000_0000, "R2 pending bit reads back");

    write_reg(2'd0, 32'h0000_0000);
    expect_out(3'd5, 8'd65, "R3 unqualified write ignored");
    check_rd(2'd0, 32'hD000_0000, "R3 unqualified write leaves field");

    write_reg(2'd0, 32'h0000_E000);
    set_src(4, 1'b1);
    expect_out(3'd6, 8'd69, "R8 higher level wins");
    check_rd(2'd0, 32'hD000_E000, "R3 single-field write");
    set_src(4, 1'b0);
    expect_out(3'd5, 8'd65, "R7 internal follows level");

    write_reg(2'd0, 32'hD000_0000);
    expect_out(3'd0, 8'd64, "R6 acknowledge clears pending");
    check_rd(2'd0, 32'h5000_6000, "R6 pending cleared, levels kept");

    write_reg(2'd1, 32'hB000_B000);
    set_src(12, 1'b1);
    expect_out(3'd3, 8'd77, "R8 single source level 3");
    set_src(8, 1'b1);
    expect_out(3'd3, 8'd73, "R8 tie to lower index");
    write_reg(2'd1, 32'h8000_0000);
    expect_out(3'd3, 8'd77, "R4 0x8 masks source");

    write_reg(2'd3, 32'h0F00_0000);
    set_src(25, 1'b1);
    set_src(25, 1'b0);
    expect_out(3'd7, 8'd90, "R5 external 5 pulse at level 7");
    write_reg(2'd3, 32'h0000_FFFF);
    check_rd(2'd3, 32'h0F00_0000, "R2 unused fields read zero");
    expect_out(3'd7, 8'd90, "R2 unused-field write no effect");

    for (int r = 0; r < 4; r++) write_reg(2'(r), 32'h8888_8888);
    expect_out(3'd0, 8'd64, "R10 mask all");
    check_rd(2'd1, 32'h8000_8000, "R7 internal pending visible while masked");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule